// File: doc/BRIEF.md
# YCbCr to RGB Pixel Packer

This block takes one decoded pixel per transfer, as an 8-bit luma sample and two 8-bit chroma samples, and turns it into a packed RGB word. The RGB word takes one of eight layouts: four 32-bit layouts with a constant alpha byte, two 24-bit layouts and two 16-bit 5-6-5 layouts. Beside the word it reports how many of its low-order bytes are meaningful, so a downstream memory writer can step its byte address without decoding the format again. When conversion is disabled, the samples leave the block unchanged.

A 16-bit control word supplies the settings. Bit 0 turns conversion on, bits [3:1] select the layout and bits [15:8] give the alpha constant, which is normally 255. Bits [7:4] are ignored. The block uses a valid/ready handshake and two register stages. The first stage forms the chroma products. The second stage rounds, saturates and packs. The control word is captured together with each pixel, so software or a sequencer may change it between pixels without disturbing pixels already in flight.

A separate combinational path turns the pixel x coordinate of a crop window's output origin into a byte offset for the layout currently selected.

Top module: `ycc_rgb_packer`

## Requirements
- R1: When control bit 0 is clear, the output word is {8'h00, Y, Cb, Cr} and the byte count is 3.
- R2: When conversion is enabled, each channel is floor((256·Y + k·(C−128) + 128) / 256), saturated to 0..255. R uses 359 on Cr. G uses −88 on Cb and −183 on Cr. B uses 454 on Cb.
- R3: Layout codes 0 to 3 in bits [3:1] give, from bit 31 down: code 0 = A,R,G,B; code 1 = A,B,G,R; code 2 = R,G,B,A; code 3 = B,G,R,A. A is control bits [15:8].
- R4: Code 4 gives {8'h00,R,G,B} and code 5 gives {8'h00,B,G,R}.
- R5: Code 6 gives {16'h0, R[7:3], G[7:2], B[7:3]} and code 7 gives {16'h0, B[7:3], G[7:2], R[7:3]}.
- R6: The byte count is 4 for codes 0 to 3, 3 for codes 4 and 5, and 2 for codes 6 and 7.
- R7: crop_x_bytes equals crop_x_px times the byte count of the code in the current control word, combinationally and whatever the enable bit.
- R8: Every accepted pixel leaves exactly once, in acceptance order. While out_valid is high and out_ready is low, the output word and byte count hold. in_ready is high whenever out_valid is low.
- R9: Each pixel is converted with the control word present in the cycle it was accepted, not with later values.
- R10: During and after reset, out_valid is low and in_ready is high until a pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Enable bit 0, layout code [3:1], alpha [15:8] |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_y | input | 8 | Luma sample |
| in_cb | input | 8 | Blue-difference chroma sample |
| in_cr | input | 8 | Red-difference chroma sample |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_pixel | output | 32 | Right-aligned packed pixel |
| out_nbytes | output | 3 | Meaningful bytes in out_pixel |
| crop_x_px | input | XW (12) | Crop output origin, in pixels |
| crop_x_bytes | output | XW+2 (14) | Crop output origin, in bytes |

## Verification
Two events can fall in the same cycle: a new control word arriving, and a stalled pixel that still carries the old word sitting in the pipeline. The bench provokes this by changing the layout, enable and alpha with every pixel while out_ready drops on a pseudo-random pattern, which keeps pixels of different layouts in both stages at once. Each output word is compared against a value computed from the control word in force in the pixel's own acceptance cycle. The crop offset is checked for every layout during the same run.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  localparam int SW     = 8;
  localparam int CF_FRAC = 8;
  localparam int ACC_W  = 20;
  localparam int OUT_W  = 32;
  localparam int NB_W   = 3;

  localparam logic signed [ACC_W-1:0] K_R_CR = 20'sd359;
  localparam logic signed [ACC_W-1:0] K_G_CB = 20'sd88;
  localparam logic signed [ACC_W-1:0] K_G_CR = 20'sd183;
  localparam logic signed [ACC_W-1:0] K_B_CB = 20'sd454;

  typedef enum logic [2:0] {
    FMT_ARGB32 = 3'd0,
    FMT_ABGR32 = 3'd1,
    FMT_RGBA32 = 3'd2,
    FMT_BGRA32 = 3'd3,
    FMT_RGB24  = 3'd4,
    FMT_BGR24  = 3'd5,
    FMT_RGB16  = 3'd6,
    FMT_BGR16  = 3'd7
  } pix_fmt_e;

  typedef struct packed {
    logic          en;
    pix_fmt_e      fmt;
    logic [SW-1:0] alpha;
  } cvt_cfg_t;

  function automatic cvt_cfg_t decode_cfg(input logic [15:0] w);
    cvt_cfg_t c;
    c.en    = w[0];
    c.fmt   = pix_fmt_e'(w[3:1]);
    c.alpha = w[15:8];
    return c;
  endfunction

  function automatic logic [NB_W-1:0] fmt_bytes(input pix_fmt_e f);
    logic [NB_W-1:0] n;
    case (f)
      FMT_RGB24, FMT_BGR24: n = 3'd3;
      FMT_RGB16, FMT_BGR16: n = 3'd2;
      default:              n = 3'd4;
    endcase
    return n;
  endfunction

  function automatic logic [SW-1:0] sat8(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] s;
    logic [SW-1:0] r;
    s = acc >>> CF_FRAC;
    if (s < 0)
      r = '0;
    else if (s > 20'sd255)
      r = '1;
    else
      r = s[SW-1:0];
    return r;
  endfunction

endpackage

// File: rtl/ycc_mul_stage.sv
module ycc_mul_stage
  import ycc_pkg::*;
(
  input  logic                    clk,
  input  logic                    load,
  input  logic [SW-1:0]           y_i,
  input  logic [SW-1:0]           cb_i,
  input  logic [SW-1:0]           cr_i,
  input  cvt_cfg_t                cfg_i,
  output logic [SW-1:0]           y_q,
  output logic [SW-1:0]           cb_q,
  output logic [SW-1:0]           cr_q,
  output logic signed [ACC_W-1:0] tr_q,
  output logic signed [ACC_W-1:0] tg_q,
  output logic signed [ACC_W-1:0] tb_q,
  output cvt_cfg_t                cfg_q
);

  logic signed [ACC_W-1:0] dcb, dcr;
  logic signed [ACC_W-1:0] tr_d, tg_d, tb_d;

  always_comb begin
    dcb  = $signed({{(ACC_W-SW){1'b0}}, cb_i}) - 20'sd128;
    dcr  = $signed({{(ACC_W-SW){1'b0}}, cr_i}) - 20'sd128;
    tr_d = K_R_CR * dcr;
    tg_d = -(K_G_CB * dcb) - (K_G_CR * dcr);
    tb_d = K_B_CB * dcb;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      y_q   <= y_i;
      cb_q  <= cb_i;
      cr_q  <= cr_i;
      tr_q  <= tr_d;
      tg_q  <= tg_d;
      tb_q  <= tb_d;
      cfg_q <= cfg_i;
    end
  end

endmodule

// File: rtl/ycc_pack_stage.sv
module ycc_pack_stage
  import ycc_pkg::*;
(
  input  logic                    clk,
  input  logic                    load,
  input  logic [SW-1:0]           y_i,
  input  logic [SW-1:0]           cb_i,
  input  logic [SW-1:0]           cr_i,
  input  logic signed [ACC_W-1:0] tr_i,
  input  logic signed [ACC_W-1:0] tg_i,
  input  logic signed [ACC_W-1:0] tb_i,
  input  cvt_cfg_t                cfg_i,
  output logic [OUT_W-1:0]        pix_q,
  output logic [NB_W-1:0]         nb_q
);

  localparam logic signed [ACC_W-1:0] HALF = 20'sd128;

  logic signed [ACC_W-1:0] ybase;
  logic [SW-1:0]           r, g, b, a;
  logic [OUT_W-1:0]        pix_d;
  logic [NB_W-1:0]         nb_d;

  always_comb begin
    ybase = $signed({{(ACC_W-SW-CF_FRAC){1'b0}}, y_i, {CF_FRAC{1'b0}}});
    r     = sat8(ybase + tr_i + HALF);
    g     = sat8(ybase + tg_i + HALF);
    b     = sat8(ybase + tb_i + HALF);
    a     = cfg_i.alpha;
    if (!cfg_i.en) begin
      pix_d = {8'h00, y_i, cb_i, cr_i};
      nb_d  = 3'd3;
    end else begin
      case (cfg_i.fmt)
        FMT_ARGB32: pix_d = {a, r, g, b};
        FMT_ABGR32: pix_d = {a, b, g, r};
        FMT_RGBA32: pix_d = {r, g, b, a};
        FMT_BGRA32: pix_d = {b, g, r, a};
        FMT_RGB24:  pix_d = {8'h00, r, g, b};
        FMT_BGR24:  pix_d = {8'h00, b, g, r};
        FMT_RGB16:  pix_d = {16'h0000, r[7:3], g[7:2], b[7:3]};
        default:    pix_d = {16'h0000, b[7:3], g[7:2], r[7:3]};
      endcase
      nb_d = fmt_bytes(cfg_i.fmt);
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      pix_q <= pix_d;
      nb_q  <= nb_d;
    end
  end

endmodule

// File: rtl/ycc_crop_offset.sv
module ycc_crop_offset
  import ycc_pkg::*;
#(
  parameter int XW = 12
) (
  input  logic [XW-1:0] x_px,
  input  pix_fmt_e      fmt,
  output logic [XW+1:0] x_bytes
);

  logic [XW+1:0] x_ext;

  always_comb begin
    x_ext = {2'b00, x_px};
    case (fmt_bytes(fmt))
      3'd2:    x_bytes = x_ext << 1;
      3'd3:    x_bytes = (x_ext << 1) + x_ext;
      default: x_bytes = x_ext << 2;
    endcase
  end

endmodule

// File: rtl/ycc_rgb_packer.sv
module ycc_rgb_packer
  import ycc_pkg::*;
#(
  parameter int XW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cfg_word,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_y,
  input  logic [7:0]       in_cb,
  input  logic [7:0]       in_cr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_pixel,
  output logic [2:0]       out_nbytes,
  input  logic [XW-1:0]    crop_x_px,
  output logic [XW+1:0]    crop_x_bytes
);

  cvt_cfg_t                cfg_now, cfg_s1;
  logic                    cfg_unused;
  logic                    v1_q, v2_q, v1_d, v2_d;
  logic                    rdy1, rdy2, load1, load2;
  logic [SW-1:0]           y_s1, cb_s1, cr_s1;
  logic signed [ACC_W-1:0] tr_s1, tg_s1, tb_s1;

  assign cfg_now    = decode_cfg(cfg_word);
  assign cfg_unused = ^cfg_word[7:4];

  // next-state of the two valid flags
  always_comb begin
    rdy2  = !v2_q || out_ready;
    rdy1  = !v1_q || rdy2;
    load1 = in_valid && rdy1;
    load2 = v1_q && rdy2;
    v1_d  = load1 || (v1_q && !load2);
    v2_d  = load2 || (v2_q && !out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  ycc_mul_stage u_mul (
    .clk   (clk),
    .load  (load1),
    .y_i   (in_y),
    .cb_i  (in_cb),
    .cr_i  (in_cr),
    .cfg_i (cfg_now),
    .y_q   (y_s1),
    .cb_q  (cb_s1),
    .cr_q  (cr_s1),
    .tr_q  (tr_s1),
    .tg_q  (tg_s1),
    .tb_q  (tb_s1),
    .cfg_q (cfg_s1)
  );

  ycc_pack_stage u_pack (
    .clk   (clk),
    .load  (load2),
    .y_i   (y_s1),
    .cb_i  (cb_s1),
    .cr_i  (cr_s1),
    .tr_i  (tr_s1),
    .tg_i  (tg_s1),
    .tb_i  (tb_s1),
    .cfg_i (cfg_s1),
    .pix_q (out_pixel),
    .nb_q  (out_nbytes)
  );

  ycc_crop_offset #(.XW(XW)) u_crop (
    .x_px    (crop_x_px),
    .fmt     (cfg_now.fmt),
    .x_bytes (crop_x_bytes)
  );

  assign in_ready  = rdy1;
  assign out_valid = v2_q;

endmodule

// File: rtl/ycc_rgb_packer_chk.sv
module ycc_rgb_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_pixel,
  input logic [2:0]  out_nbytes
);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel) && $stable(out_nbytes));

  assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_pad_24bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_nbytes == 3'd3 |-> out_pixel[31:24] == 8'h00);

  assert_pad_16bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_nbytes == 3'd2 |-> out_pixel[31:16] == 16'h0000);

  assert_byte_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_nbytes inside {3'd2, 3'd3, 3'd4});

endmodule

bind ycc_rgb_packer ycc_rgb_packer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pixel  (out_pixel),
  .out_nbytes (out_nbytes)
);

// File: tb/ycc_rgb_packer_bench.sv
module ycc_rgb_packer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int XW = 12;

  logic          clk, rst_n;
  logic [15:0]   cfg_word;
  logic          in_valid, in_ready;
  logic [7:0]    in_y, in_cb, in_cr;
  logic          out_valid, out_ready;
  logic [31:0]   out_pixel;
  logic [2:0]    out_nbytes;
  logic [XW-1:0] crop_x_px;
  logic [XW+1:0] crop_x_bytes;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] q_pix[$];
  logic [2:0]  q_nb[$];
  string       q_tag[$];

  ycc_rgb_packer #(.XW(XW)) u_ycc_rgb_packer (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel), .out_nbytes(out_nbytes),
    .crop_x_px(crop_x_px), .crop_x_bytes(crop_x_bytes)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    int s;
    s = v >>> 8;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic int bytes_of(input int f);
    if (f < 4) return 4;
    if (f < 6) return 3;
    return 2;
  endfunction

  task automatic model(input int y, input int cb, input int cr, input logic [15:0] cw,
                       output logic [31:0] pix, output logic [2:0] nb, output string tag);
    int r, g, b, f;
    logic [7:0] a, r8, g8, b8;
    f  = int'(cw[3:1]);
    a  = cw[15:8];
    r  = sat(256*y + 359*(cr-128) + 128);
    g  = sat(256*y - 88*(cb-128) - 183*(cr-128) + 128);
    b  = sat(256*y + 454*(cb-128) + 128);
    r8 = r[7:0]; g8 = g[7:0]; b8 = b[7:0];
    if (!cw[0]) begin
      pix = {8'h00, y[7:0], cb[7:0], cr[7:0]}; nb = 3'd3; tag = "R1";
    end else begin
      nb = 3'(bytes_of(f));
      case (f)
        0: begin pix = {a, r8, g8, b8}; tag = "R3"; end
        1: begin pix = {a, b8, g8, r8}; tag = "R3"; end
        2: begin pix = {r8, g8, b8, a}; tag = "R3"; end
        3: begin pix = {b8, g8, r8, a}; tag = "R3"; end
        4: begin pix = {8'h00, r8, g8, b8}; tag = "R4"; end
        5: begin pix = {8'h00, b8, g8, r8}; tag = "R4"; end
        6: begin pix = {16'h0, r8[7:3], g8[7:2], b8[7:3]}; tag = "R5"; end
        default: begin pix = {16'h0, b8[7:3], g8[7:2], r8[7:3]}; tag = "R5"; end
      endcase
    end
  endtask

  // one bench cycle: drive at negedge, observe both handshakes, return whether input was taken
  task automatic cycle(input bit have, input int y, input int cb, input int cr,
                       input logic [15:0] cw, input bit rdy, output bit taken);
    logic [31:0] ep;
    logic [2:0]  en;
    string       tg;
    @(negedge clk);
    in_valid  = have;
    in_y      = y[7:0];
    in_cb     = cb[7:0];
    in_cr     = cr[7:0];
    cfg_word  = cw;
    out_ready = rdy;
    #1;
    if (out_valid && out_ready) begin
      if (q_pix.size() == 0) begin
        check("R8 unexpected output", out_pixel, 32'hxxxxxxxx);
      end else begin
        // R2 R9: value computed from the word present when the pixel was accepted
        check({q_tag[0], " R2 R9 pixel"}, out_pixel, q_pix[0]);
        check("R6 byte count", {29'd0, out_nbytes}, {29'd0, q_nb[0]});
        void'(q_pix.pop_front()); void'(q_nb.pop_front()); void'(q_tag.pop_front());
      end
    end
    taken = in_valid && in_ready;
    if (taken) begin
      model(y, cb, cr, cw, ep, en, tg);
      q_pix.push_back(ep); q_nb.push_back(en); q_tag.push_back(tg);
    end
  endtask

  function automatic int sample_val(input int i);
    case (i)
      0: return 0;   1: return 16;  2: return 64;  3: return 128;
      4: return 192; 5: return 240; default: return 255;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit tk;
    int idx;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_y = '0; in_cb = '0; in_cr = '0; cfg_word = 16'hFF01; crop_x_px = '0;
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R10 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R10 in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R7: crop byte offset for every code, both enable states
    for (int f = 0; f < 8; f++) begin
      for (int e = 0; e < 2; e++) begin
        for (int k = 0; k < 5; k++) begin
          int x;
          x = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 5 : (k == 3) ? 1000 : 4095;
          cfg_word  = {8'h80, 4'h0, f[2:0], e[0]};
          crop_x_px = x[XW-1:0];
          #1;
          check("R7 crop byte offset", {18'd0, crop_x_bytes}, 32'(x * bytes_of(f)));
        end
      end
    end

    // near-exhaustive sweep, layout/enable/alpha changing every pixel, random stalls
    idx = 0;
    for (int yi = 0; yi < 7; yi++) begin
      for (int bi = 0; bi < 7; bi++) begin
        for (int ri = 0; ri < 7; ri++) begin
          for (int m = 0; m < 16; m++) begin
            logic [15:0] cw;
            int code;
            code = (m + idx) % 16;
            cw = {8'(idx * 37 + 5), 4'h0, code[2:0], code[3]};
            idx++;
            tk = 1'b0;
            while (!tk)
              cycle(1'b1, sample_val(yi), sample_val(bi), sample_val(ri), cw,
                    ($urandom % 4) != 0, tk);
            if ((idx % 13) == 0) cycle(1'b0, 0, 0, 0, cw, 1'b1, tk);
          end
        end
      end
    end

    // long stall then drain
    for (int s = 0; s < 6; s++) cycle(1'b0, 0, 0, 0, 16'h0001, 1'b0, tk);
    for (int s = 0; s < 20 && q_pix.size() > 0; s++) cycle(1'b0, 0, 0, 0, 16'h0001, 1'b1, tk);
    check("R8 all accepted pixels delivered", 32'(q_pix.size()), 32'd0);
    @(negedge clk);
    check("R8 pipeline empty at end", {31'd0, out_valid}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule